// File: doc/BRIEF.md
# Flash Completion Status Poller

After a host has issued a program or erase command to a parallel NOR flash, this block decides how the operation ended. It reads the status byte over a request/acknowledge memory port and compares the toggle bit (bit 6) of two back-to-back reads. A stable bit means the operation completed. A toggling bit with the time-limit bit (bit 5) clear means the operation is still running, so another read pair follows. A toggling bit with bit 5 set leads to one final read pair. That pair catches an operation that finished at the same moment the limit bit rose.

On any failure the block writes the reset command byte 0xF0 to the target address, which puts the flash back into array-read mode, and only then signals completion. A programmable budget of read pairs bounds the loop. A new start while a job is running abandons the job: all earlier samples are discarded and polling begins again from a fresh read pair.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no start, done_o, pass_o, limit_o and req_o are 0.
- R2: After start_i, two reads are issued at the latched target address. If bit 6 is equal in both bytes, the job ends with pass_o=1 after exactly those reads, and no write is issued.
- R3: If bit 6 differs between the two reads and bit 5 of the second read is 0, a further read pair is issued. Its result is judged with the same rules.
- R4: If bit 6 differs and bit 5 of the second read is 1, exactly one more pair is read. If bit 6 is equal in that pair the job passes. If it still differs the job fails.
- R5: Every failed job issues one write of 0xF0 to the target address before done_o, and reports pass_o=0.
- R6: A start_i that arrives during a job lets any outstanding access finish and discards its data. Polling then restarts from a fresh pair at the new address, with a new budget.
- R7: After max_polls_i consecutive pairs in which bit 6 toggles with bit 5 clear (a value of 0 counts as 1), the job fails with limit_o=1 and issues the reset write.
- R8: req_o, we_o, req_addr_o and wdata_o stay constant until ack_i is sampled high. Only one access is outstanding at any time.
- R9: done_o is a single-cycle pulse. pass_o and limit_o hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start (or restart) polling pulse |
| addr_i | input | AW | Target flash address for the job |
| max_polls_i | input | CW | Budget of toggling read pairs |
| done_o | output | 1 | Job complete, one-cycle pulse |
| pass_o | output | 1 | Operation completed successfully |
| limit_o | output | 1 | Failure caused by the poll budget |
| req_o | output | 1 | Memory access request |
| we_o | output | 1 | Access is a write |
| req_addr_o | output | AW | Access address |
| wdata_o | output | 8 | Write data |
| ack_i | input | 1 | Access acknowledge / read data valid |
| rdata_i | input | 8 | Read data |

## Verification
Directed status streams cover each branch in isolation:
- an immediately stable pair;
- a slow operation with bit 5 clear;
- a late completion after bit 5 rises;
- a toggle that persists after bit 5 rises;
- a stream that exhausts the budget.

The pass, limit and read-count results of these streams show which branch was taken. Random streams are mixed in, with a random per-byte bit 6 phase, a rare bit 5 and random budgets, so that the order of branch decisions varies. A restart issued mid-access with a stable new stream shows whether stale samples or the old address leak into the new job. Random acknowledge latency exercises the request hold rule.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned TOGGLE_BIT = 6;
  localparam int unsigned LIMIT_BIT  = 5;
  localparam logic [DATA_W-1:0] RESET_CMD = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_EVAL,
    ST_RST_WR,
    ST_DONE
  } poll_state_e;
endpackage

// File: rtl/sample_pair.sv
module sample_pair
  import flash_poll_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              slot_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              toggled_o,
  output logic              late_o
);
  logic [DATA_W-1:0] smp_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          smp_q[g] <= '0;
      else if (clr_i)                       smp_q[g] <= '0;
      else if (cap_i && (slot_i == g[0]))   smp_q[g] <= data_i;
    end
  end

  assign toggled_o = smp_q[0][TOGGLE_BIT] ^ smp_q[1][TOGGLE_BIT];
  assign late_o    = smp_q[1][LIMIT_BIT];
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] max_i,
  input  logic          step_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, lim_q;
  logic [CW:0]   nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= CW'(1);
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= (max_i == '0) ? CW'(1) : max_i;
    end else if (step_i && !last_o) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign nxt    = {1'b0, cnt_q} + (CW+1)'(1);
  assign last_o = nxt >= {1'b0, lim_q};

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < lim_q);
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int unsigned AW = 19,
  parameter int unsigned CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [CW-1:0]     max_polls_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              limit_o,
  output logic              req_o,
  output logic              we_o,
  output logic [AW-1:0]     req_addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i
);
  poll_state_e state_q, state_d;
  logic [AW-1:0] addr_q, pend_q;
  logic restart_q, recheck_q, pass_q, lim_q, wr_seen_q;
  logic load, cap, slot, step, set_recheck, dec_pass, dec_fail, dec_lim;
  logic start_any, acc_st, acked, toggled, late, last;

  assign acc_st    = (state_q == ST_RD_A) || (state_q == ST_RD_B) || (state_q == ST_RST_WR);
  assign acked     = acc_st && ack_i;
  assign start_any = start_i || restart_q;

  sample_pair i_samples (
    .clk_i, .rst_ni,
    .clr_i    (load),
    .cap_i    (cap),
    .slot_i   (slot),
    .data_i   (rdata_i),
    .toggled_o(toggled),
    .late_o   (late)
  );

  poll_budget #(.CW(CW)) i_budget (
    .clk_i, .rst_ni,
    .load_i (load),
    .max_i  (max_polls_i),
    .step_i (step),
    .last_o (last)
  );

  always_comb begin
    state_d = state_q;
    load = 1'b0; cap = 1'b0; slot = 1'b0; step = 1'b0;
    set_recheck = 1'b0; dec_pass = 1'b0; dec_fail = 1'b0; dec_lim = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_any)               load = 1'b1;
        else if (state_q == ST_DONE) state_d = ST_IDLE;
      end
      ST_RD_A: if (acked) begin
        if (start_any) load = 1'b1;
        else begin cap = 1'b1; slot = 1'b0; state_d = ST_RD_B; end
      end
      ST_RD_B: if (acked) begin
        if (start_any) load = 1'b1;
        else begin cap = 1'b1; slot = 1'b1; state_d = ST_EVAL; end
      end
      ST_EVAL: begin
        if (start_any) load = 1'b1;
        else if (!toggled) begin
          dec_pass = 1'b1; state_d = ST_DONE;
        end else if (recheck_q) begin
          dec_fail = 1'b1; state_d = ST_RST_WR;
        end else if (late) begin
          set_recheck = 1'b1; state_d = ST_RD_A;
        end else if (last) begin
          dec_fail = 1'b1; dec_lim = 1'b1; state_d = ST_RST_WR;
        end else begin
          step = 1'b1; state_d = ST_RD_A;
        end
      end
      ST_RST_WR: if (acked) begin
        if (start_any) load = 1'b1;
        else state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (load) state_d = ST_RD_A;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      pend_q    <= '0;
      restart_q <= 1'b0;
      recheck_q <= 1'b0;
      pass_q    <= 1'b0;
      lim_q     <= 1'b0;
      wr_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i) pend_q <= addr_i;
      if (load) begin
        addr_q    <= start_i ? addr_i : pend_q;
        restart_q <= 1'b0;
        recheck_q <= 1'b0;
        pass_q    <= 1'b0;
        lim_q     <= 1'b0;
        wr_seen_q <= 1'b0;
      end else begin
        if (start_i && acc_st) restart_q <= 1'b1;
        if (set_recheck)       recheck_q <= 1'b1;
        if (dec_pass)          pass_q    <= 1'b1;
        if (dec_fail)          pass_q    <= 1'b0;
        if (dec_lim)           lim_q     <= 1'b1;
        if (acked && we_o)     wr_seen_q <= 1'b1;
      end
    end
  end

  assign req_o      = acc_st;
  assign we_o       = (state_q == ST_RST_WR);
  assign req_addr_o = addr_q;
  assign wdata_o    = we_o ? RESET_CMD : '0;
  assign done_o     = (state_q == ST_DONE);
  assign pass_o     = pass_q;
  assign limit_o    = lim_q;

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(req_addr_o) && $stable(we_o) && $stable(wdata_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  fail_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !pass_o |-> wr_seen_q);
  // R2
  pass_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && pass_o |-> !wr_seen_q && !limit_o);
  // R7
  limit_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(limit_o) |-> !pass_o);
endmodule

// File: tb/test_flash_poll_ctrl.sv
module test_flash_poll_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [CW-1:0] max_polls_i = '0;
  logic done_o, pass_o, limit_o, req_o, we_o;
  logic [AW-1:0] req_addr_o;
  logic [7:0] wdata_o;
  logic ack_i = 1'b0;
  logic [7:0] rdata_i = '0;

  flash_poll_ctrl #(.AW(AW), .CW(CW)) i_flash_poll_ctrl (
    .clk_i(clk), .rst_ni, .start_i, .addr_i, .max_polls_i,
    .done_o, .pass_o, .limit_o, .req_o, .we_o, .req_addr_o, .wdata_o,
    .ack_i, .rdata_i
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  logic [7:0] script [64];
  int idx, rd_cnt, wr_cnt, addr_err, hold_err, dly;
  logic [7:0] last_wdata;
  logic [AW-1:0] exp_addr, last_waddr;
  logic junk = 1'b0;
  logic hold_armed = 1'b0;
  logic [AW-1:0] hold_addr;
  logic hold_we;
  bit exp_pass, exp_lim;
  int exp_rd;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // memory responder
  always @(negedge clk) begin
    if (hold_armed && (!req_o || req_addr_o != hold_addr || we_o != hold_we)) hold_err++;
    hold_armed = 1'b0;
    if (ack_i) ack_i = 1'b0;
    else if (req_o) begin
      if (dly == 0) begin
        ack_i = 1'b1;
        if (we_o) begin
          wr_cnt++; last_wdata = wdata_o; last_waddr = req_addr_o;
        end else if (junk) begin
          rdata_i = 8'h40; junk = 1'b0;
        end else begin
          rdata_i = script[idx]; idx++; rd_cnt++;
          if (req_addr_o != exp_addr) addr_err++;
        end
        dly = int'($urandom % 3);
      end else begin
        dly--;
        hold_armed = 1'b1; hold_addr = req_addr_o; hold_we = we_o;
      end
    end
  end

  function automatic void ref_eval(input int m);
    int meff = (m == 0) ? 1 : m;
    int i = 0, pairs = 0;
    bit rechk = 0;
    exp_pass = 0; exp_lim = 0;
    forever begin
      bit t = script[i][6] ^ script[i+1][6];
      bit l = script[i+1][5];
      i += 2;
      if (!t) begin exp_pass = 1; break; end
      else if (rechk) break;
      else if (l) rechk = 1;
      else begin
        pairs++;
        if (pairs >= meff) begin exp_lim = 1; break; end
      end
    end
    exp_rd = i;
  endfunction

  task automatic arm(input logic [AW-1:0] a);
    idx = 0; rd_cnt = 0; wr_cnt = 0; addr_err = 0; hold_err = 0;
    exp_addr = a; last_wdata = '0; last_waddr = '0;
  endtask

  task automatic wait_check(input string req);
    int n = 0;
    while (!done_o && n < 3000) begin @(negedge clk); n++; end
    chk(done_o, req, "done seen", int'(done_o), 1);
    chk(pass_o == exp_pass, req, "pass", int'(pass_o), int'(exp_pass));
    chk(limit_o == exp_lim, req, "limit (R7)", int'(limit_o), int'(exp_lim));
    chk(rd_cnt == exp_rd, req, "read count (R3/R4)", rd_cnt, exp_rd);
    chk(wr_cnt == (exp_pass ? 0 : 1), req, "reset writes (R5)", wr_cnt, exp_pass ? 0 : 1);
    if (!exp_pass) begin
      chk(last_wdata == 8'hF0, req, "reset byte (R5)", int'(last_wdata), 'hF0);
      chk(last_waddr == exp_addr, req, "reset addr (R5)", int'(last_waddr), int'(exp_addr));
    end
    chk(addr_err == 0, req, "read address (R2)", addr_err, 0);
    chk(hold_err == 0, req, "request hold (R8)", hold_err, 0);
    @(negedge clk);
    chk(!done_o, req, "done pulse width (R9)", int'(done_o), 0);
    chk(pass_o == exp_pass && limit_o == exp_lim, req, "result held (R9)",
        int'({pass_o, limit_o}), int'({exp_pass, exp_lim}));
  endtask

  task automatic run_job(input logic [AW-1:0] a, input int m, input string req);
    ref_eval(m);
    arm(a);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; max_polls_i = CW'(m);
    @(negedge clk);
    start_i = 1'b0;
    wait_check(req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    dly = 0;
    repeat (3) @(negedge clk);
    chk(!done_o && !pass_o && !limit_o && !req_o, "R1", "outputs in reset",
        int'({done_o, pass_o, limit_o, req_o}), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done_o && !pass_o && !limit_o && !req_o, "R1", "outputs idle",
        int'({done_o, pass_o, limit_o, req_o}), 0);

    // R2 stable first pair
    script[0] = 8'h12; script[1] = 8'h12;
    run_job(19'h1_2345, 4, "R2");
    // R3 toggling then stable
    script[0] = 8'h40; script[1] = 8'h00; script[2] = 8'h00; script[3] = 8'h00;
    run_job(19'h0_0555, 4, "R3");
    // R4 late completion
    script[0] = 8'h40; script[1] = 8'h20; script[2] = 8'h20; script[3] = 8'h20;
    run_job(19'h7_0000, 4, "R4");
    // R4 / R5 still toggling after bit 5
    script[0] = 8'h40; script[1] = 8'h20; script[2] = 8'h60; script[3] = 8'h20;
    run_job(19'h3_ABCD, 4, "R5");
    // R7 budget exhausted, and zero budget
    for (int i = 0; i < 64; i++) script[i] = (i % 2 == 0) ? 8'h40 : 8'h00;
    run_job(19'h5_5555, 3, "R7");
    run_job(19'h0_0001, 0, "R7");

    // R6 restart mid-access with a stable stream at a new address
    for (int i = 0; i < 64; i++) script[i] = (i % 2 == 0) ? 8'h40 : 8'h00;
    arm(19'h1_1111);
    @(negedge clk);
    start_i = 1'b1; addr_i = 19'h1_1111; max_polls_i = CW'(8);
    @(negedge clk);
    start_i = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (rd_cnt >= 3 && req_o && !ack_i && !we_o) break;
    end
    for (int i = 0; i < 64; i++) script[i] = 8'h00;
    idx = 0; rd_cnt = 0; exp_addr = 19'h6_0F0F; junk = 1'b1;
    start_i = 1'b1; addr_i = 19'h6_0F0F;
    @(negedge clk);
    start_i = 1'b0;
    exp_pass = 1; exp_lim = 0; exp_rd = 2;
    wait_check("R6");

    // random streams
    for (int j = 0; j < 40; j++) begin
      int m = 1 + int'($urandom % 5);
      for (int i = 0; i < 64; i++) begin
        logic [7:0] b = 8'($urandom);
        b[6] = (i[0]) ^ ($urandom % 4 == 0);
        b[5] = ($urandom % 5 == 0);
        script[i] = b;
      end
      run_job(AW'($urandom), m, "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule